// File: doc/BRIEF.md
# Parallel Port Register Interface

This block presents a PC-style parallel port to a host bus as three byte-wide registers: a data register, a read-only device status register and a device control register. The host reaches them through a plain read/write port with a 2-bit address. The read data path is combinational on the address. On the pin side the block has separate data-out, data-in and output-enable signals, four active-low control outputs and five status inputs.

The status inputs pass through a synchronizer before the host can read them. The synchronized acknowledge input also feeds a rising-edge detector. When the interrupt-enable control bit is set, each rising edge produces a one-cycle interrupt pulse and sets a sticky flag. A host read of the status register clears that flag.

A mode input selects compatible or extended operation. Only in extended mode can the direction control bit release the data drivers.

Top module: `pport_regs`

## Requirements
- R1: Status register (address 1), after the synchronizer latency of SYNC_STAGES cycles: bit 7 reads as the inverse of `busy_i`; bits 6, 5, 4 and 3 read `nack_i`, `perror_i`, `select_i` and `nfault_i` unchanged. Bits 2..0 are reserved and software ignores them.
- R2: A host write to the status register changes neither the data register, nor the control register, nor any output pin.
- R3: Control register (address 2) holds six bits and reads back with bits 7..6 as zero. Bit 0 drives `nstrobe_o` inverted, bit 1 drives `nautofd_o` inverted, bit 3 drives `nselectin_o` inverted and bit 2 drives `ninit_o` unchanged.
- R4: After reset the control register is zero, so `nstrobe_o`, `nautofd_o` and `nselectin_o` are high and `ninit_o` is low. Also after reset `pd_oe` is high, `pd_out` is zero and `irq_flag` is clear.
- R5: A write to the data register (address 0) appears on `pd_out`. A read of address 0 returns the current value of `pd_in`, not the value last written.
- R6: With `ext_mode` high and control bit 5 (direction) set, `pd_oe` is low. With `ext_mode` high and bit 5 clear, `pd_oe` is high.
- R7: With `ext_mode` low, `pd_oe` stays high whatever the value of control bit 5.
- R8: With control bit 4 (interrupt enable) set, each rising edge on `nack_i` gives exactly one single-cycle pulse on `irq_pulse`. A falling edge gives none.
- R9: With control bit 4 clear, a rising edge on `nack_i` gives no pulse and leaves `irq_flag` clear.
- R10: `irq_flag` is set by each interrupt pulse and cleared by a host read of the status register. If a new pulse and a status read fall on the same cycle, the flag stays set.
- R11: Address 3 reads as zero, and a write to it changes no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (a status read clears the flag) |
| addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 unused |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for the addressed register |
| ext_mode | input | 1 | 1 = extended mode, 0 = compatible mode |
| pd_out | output | 8 | Data line output value |
| pd_in | input | 8 | Data line sampled value |
| pd_oe | output | 1 | Data line driver enable |
| busy_i | input | 1 | Busy status input |
| nack_i | input | 1 | Acknowledge status input, active low |
| perror_i | input | 1 | Paper error status input |
| select_i | input | 1 | Select status input |
| nfault_i | input | 1 | Fault status input, active low |
| nstrobe_o | output | 1 | Strobe output, active low |
| nautofd_o | output | 1 | Auto-feed output, active low |
| ninit_o | output | 1 | Initialize output, active low |
| nselectin_o | output | 1 | Select-in output, active low |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This tests that the status read latency and the interrupt timing follow the parameter and are not fixed at two cycles. With the extended-mode variant enabled, both the direction path and its suppression in compatible mode can be exercised. The bench also places a status read on the exact cycle that a 3-stage chain delivers an acknowledge edge. This makes the set-over-clear priority of the sticky flag observable.

// File: rtl/pport_pkg.sv
package pport_pkg;
   localparam int BYTE_W = 8;
   localparam int CTRL_W = 6;
   localparam int STAT_W = 5;

   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_STAT = 2'd1,
      REG_CTRL = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   // control bit positions: pin mapping depends on them
   localparam int CB_STROBE = 0;
   localparam int CB_AUTOFD = 1;
   localparam int CB_INIT   = 2;
   localparam int CB_SELIN  = 3;
   localparam int CB_IRQEN  = 4;
   localparam int CB_DIR    = 5;

   // per-pin inversion for control bits 3..0
   localparam logic [3:0] PIN_INV = 4'b1011;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
   parameter int W       = 5,
   parameter int STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pport_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("pport_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= {W{RST_VAL}};
         else if (i == 0) chain[i] <= d_i;
         else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
   import pport_pkg::*;
#(
   parameter bit HAS_EXT_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [CTRL_W-1:0] wdata_i,
   input  logic              ext_mode_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [3:0]        pins_o,
   output logic              oe_o,
   output logic              irq_en_o
);
   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (we_i) ctrl_q <= wdata_i;
   end

   for (genvar p = 0; p < 4; p++) begin : g_pin
      if (PIN_INV[p]) begin : g_inv
         assign pins_o[p] = ~ctrl_q[p];
      end else begin : g_direct
         assign pins_o[p] = ctrl_q[p];
      end
   end

   if (HAS_EXT_MODE) begin : g_ext
      assign oe_o = ~(ext_mode_i & ctrl_q[CB_DIR]);
   end else begin : g_compat_only
      assign oe_o = 1'b1;
   end

   assign ctrl_o   = ctrl_q;
   assign irq_en_o = ctrl_q[CB_IRQEN];

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(ctrl_o)); // R2
endmodule

// File: rtl/pport_ackirq.sv
module pport_ackirq (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_s_i,
   input  logic irq_en_i,
   input  logic clr_i,
   output logic pulse_o,
   output logic flag_o
);
   logic ack_d;
   logic rise;
   logic fire;

   assign rise = ack_s_i & ~ack_d;
   assign fire = rise & irq_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_d   <= 1'b0;
         pulse_o <= 1'b0;
         flag_o  <= 1'b0;
      end else begin
         ack_d   <= ack_s_i;
         pulse_o <= fire;
         if (fire) flag_o <= 1'b1;
         else if (clr_i) flag_o <= 1'b0;
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o); // R8
   AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> $past(irq_en_i)); // R9
   AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> flag_o); // R10
   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !fire) |=> !flag_o); // R10
endmodule

// File: rtl/pport_regs.sv
module pport_regs
   import pport_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit HAS_EXT_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              ext_mode,
   output logic [DATA_W-1:0] pd_out,
   input  logic [DATA_W-1:0] pd_in,
   output logic              pd_oe,
   input  logic              busy_i,
   input  logic              nack_i,
   input  logic              perror_i,
   input  logic              select_i,
   input  logic              nfault_i,
   output logic              nstrobe_o,
   output logic              nautofd_o,
   output logic              ninit_o,
   output logic              nselectin_o,
   output logic              irq_pulse,
   output logic              irq_flag
);
   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("pport_regs: DATA_W must equal 8");
   end

   localparam int PAD_CTRL = DATA_W - CTRL_W;
   localparam int PAD_STAT = DATA_W - STAT_W;

   reg_sel_e sel;
   assign sel = reg_sel_e'(addr);

   // data register
   logic [DATA_W-1:0] data_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q <= '0;
      else if (wr_en && sel == REG_DATA) data_q <= wdata;
   end
   assign pd_out = data_q;

   // control register and pins
   logic [CTRL_W-1:0] ctrl;
   logic [3:0]        cpins;
   logic              irq_en;

   pport_ctrl #(.HAS_EXT_MODE(HAS_EXT_MODE)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (wr_en && sel == REG_CTRL),
      .wdata_i    (wdata[CTRL_W-1:0]),
      .ext_mode_i (ext_mode),
      .ctrl_o     (ctrl),
      .pins_o     (cpins),
      .oe_o       (pd_oe),
      .irq_en_o   (irq_en)
   );

   assign nstrobe_o   = cpins[CB_STROBE];
   assign nautofd_o   = cpins[CB_AUTOFD];
   assign ninit_o     = cpins[CB_INIT];
   assign nselectin_o = cpins[CB_SELIN];

   // status synchronizer: {busy, nack, perror, select, nfault}
   logic [STAT_W-1:0] st_raw;
   logic [STAT_W-1:0] st_s;
   assign st_raw = {busy_i, nack_i, perror_i, select_i, nfault_i};

   pport_sync #(.W(STAT_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (st_raw),
      .q_o   (st_s)
   );

   logic [DATA_W-1:0] status;
   assign status = {~st_s[STAT_W-1], st_s[STAT_W-2:0], {PAD_STAT{1'b0}}};

   pport_ackirq i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_s_i  (st_s[STAT_W-2]),
      .irq_en_i (irq_en),
      .clr_i    (rd_en && sel == REG_STAT),
      .pulse_o  (irq_pulse),
      .flag_o   (irq_flag)
   );

   always_comb begin
      unique case (sel)
         REG_DATA: rdata = pd_in;
         REG_STAT: rdata = status;
         REG_CTRL: rdata = {{PAD_CTRL{1'b0}}, ctrl};
         default:  rdata = '0;
      endcase
   end

   AST_OE_COMPAT: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_mode |-> pd_oe); // R7
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == REG_DATA) |=> $stable(pd_out)); // R2
   AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == REG_CTRL) |=> $stable({nstrobe_o, nautofd_o, ninit_o, nselectin_o})); // R11
endmodule

// File: tb/test_pport_regs.sv
module test_pport_regs;
   localparam int S = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, ext_mode = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = '0, pd_in = '0;
   logic busy_i = 1'b0, nack_i = 1'b1, perror_i = 1'b0, select_i = 1'b0, nfault_i = 1'b1;
   logic [7:0] rdata, pd_out;
   logic pd_oe, nstrobe_o, nautofd_o, ninit_o, nselectin_o, irq_pulse, irq_flag;

   int checks = 0;
   int fails = 0;
   logic [7:0] data_m = '0;
   logic [5:0] ctrl_m = '0;

   always #2.5 clk = ~clk;

   pport_regs #(.DATA_W(8), .SYNC_STAGES(S), .HAS_EXT_MODE(1'b1)) i_pport_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ext_mode(ext_mode), .pd_out(pd_out),
      .pd_in(pd_in), .pd_oe(pd_oe), .busy_i(busy_i), .nack_i(nack_i),
      .perror_i(perror_i), .select_i(select_i), .nfault_i(nfault_i),
      .nstrobe_o(nstrobe_o), .nautofd_o(nautofd_o), .ninit_o(ninit_o),
      .nselectin_o(nselectin_o), .irq_pulse(irq_pulse), .irq_flag(irq_flag)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_pins(input logic [5:0] c);
      // {nselectin, ninit, nautofd, nstrobe}
      return {~c[3], c[2], ~c[1], ~c[0]};
   endfunction

   function automatic logic exp_oe(input logic [5:0] c, input logic m);
      return !(m && c[5]);
   endfunction

   function automatic logic [4:0] exp_stat(input logic b, n, p, s, f);
      return {~b, n, p, s, f};
   endfunction

   task automatic do_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a == 2'd0) data_m = d;
      if (a == 2'd2) ctrl_m = d[5:0];
   endtask

   task automatic do_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic check_pins(input string tag);
      check(tag, {pd_out, pd_oe, nselectin_o, ninit_o, nautofd_o, nstrobe_o},
            {data_m, exp_oe(ctrl_m, ext_mode), exp_pins(ctrl_m)});
   endtask

   task automatic count_pulses(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (irq_pulse) cnt++;
      end
   endtask

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      int cnt;
      void'($urandom(32'h5eed1234));
      repeat (3) @(negedge clk);
      // R4 reset state
      check("R4 pins in reset", {pd_out, pd_oe, nstrobe_o, nautofd_o, nselectin_o, ninit_o, irq_flag},
            {8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
      rst_n = 1'b1;
      @(negedge clk);
      do_read(2'd2, rd);
      check("R4 control after reset", rd, 8'h00);

      // R1 status mapping, directed patterns
      for (int k = 0; k < 6; k++) begin
         logic [4:0] v;
         v = (k == 0) ? 5'b00000 : (k == 1) ? 5'b11111 : 5'($urandom);
         v[3] = 1'b1; // keep acknowledge idle high
         @(negedge clk);
         {busy_i, nack_i, perror_i, select_i, nfault_i} = v;
         repeat (S + 1) @(negedge clk);
         do_read(2'd1, rd);
         check("R1 status bits 7..3", rd[7:3], exp_stat(v[4], v[3], v[2], v[1], v[0]));
      end

      // R3 each control bit alone
      for (int b = 0; b < 6; b++) begin
         do_write(2'd2, 8'h01 << b);
         check_pins("R3 single control bit");
         do_read(2'd2, rd);
         check("R3 control readback", rd, {2'b00, ctrl_m});
      end
      do_write(2'd2, 8'hFF);
      do_read(2'd2, rd);
      check("R3 control upper bits zero", rd, 8'h3F);

      // R6/R7 direction vs mode
      ext_mode = 1'b1;
      do_write(2'd2, 8'h20);
      check("R6 extended dir set oe", pd_oe, 1'b0);
      do_write(2'd2, 8'h00);
      check("R6 extended dir clear oe", pd_oe, 1'b1);
      do_write(2'd2, 8'h20);
      @(negedge clk); ext_mode = 1'b0; #1;
      check("R7 compat ignores dir", pd_oe, 1'b1);

      // R5 data readback is the line value
      do_write(2'd0, 8'hA5);
      pd_in = 8'h3C;
      do_read(2'd0, rd);
      check("R5 data read is pd_in", rd, 8'h3C);
      check("R5 data drives pd_out", pd_out, 8'hA5);

      // R2 status write ignored, R11 address 3
      do_write(2'd1, 8'hFF);
      check_pins("R2 status write no pin change");
      do_read(2'd2, rd);
      check("R2 control unchanged", rd, {2'b00, ctrl_m});
      do_write(2'd3, 8'h5A);
      check_pins("R11 addr3 write no pin change");
      do_read(2'd3, rd);
      check("R11 addr3 reads zero", rd, 8'h00);
      do_read(2'd0, rd);
      check("R11 data unchanged", {rd, pd_out}, {pd_in, data_m});

      // R9 interrupt disabled
      do_write(2'd2, 8'h00);
      @(negedge clk); nack_i = 1'b0;
      repeat (S + 3) @(negedge clk);
      nack_i = 1'b1;
      count_pulses(S + 4, cnt);
      check("R9 no pulse when disabled", cnt, 0);
      check("R9 flag stays clear", irq_flag, 1'b0);

      // R8 enabled: one pulse per rising edge, none on falling
      do_write(2'd2, 8'h10);
      @(negedge clk); nack_i = 1'b0;
      count_pulses(S + 4, cnt);
      check("R8 no pulse on falling edge", cnt, 0);
      nack_i = 1'b1;
      count_pulses(S + 4, cnt);
      check("R8 one pulse on rising edge", cnt, 1);
      check("R10 flag set after pulse", irq_flag, 1'b1);
      do_read(2'd1, rd);
      check("R10 flag cleared by status read", irq_flag, 1'b0);

      // R10 set wins over clear on the same cycle
      @(negedge clk); nack_i = 1'b0;
      repeat (S + 3) @(negedge clk);
      nack_i = 1'b1;
      repeat (S) @(negedge clk);
      rd_en = 1'b1; addr = 2'd1;
      @(negedge clk);
      rd_en = 1'b0;
      check("R10 set wins over clear", irq_flag, 1'b1);
      do_read(2'd1, rd);
      check("R10 flag cleared", irq_flag, 1'b0);

      // random mix
      for (int it = 0; it < 300; it++) begin
         logic [1:0] a;
         logic [7:0] d;
         a = 2'($urandom);
         d = 8'($urandom);
         @(negedge clk);
         ext_mode = 1'($urandom);
         pd_in = 8'($urandom);
         do_write(a, d);
         #1 check_pins("R3 R6 R7 random pins");
         do_read(a, rd);
         case (a)
            2'd0: check("R5 random data read", rd, pd_in);
            2'd2: check("R3 random control read", rd, {2'b00, ctrl_m});
            2'd3: check("R11 random addr3 read", rd, 8'h00);
            default: check("R1 random status read", rd[7:3], exp_stat(busy_i, nack_i, perror_i, select_i, nfault_i));
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule